// File: doc/BRIEF.md
# Queue Status Interrupt Register Block

This block is the slave-side register file of a queued I/O controller. It holds four 32-bit words: a configuration word, a sticky slave-access error word, a command/status word and an interrupt mask word. The host reaches them through a plain word-wide port. A two-bit word index selects the register: index 0 is byte offset 0x00, index 1 is 0x04, index 2 is 0x08 and index 3 is 0x0C. A write takes effect on the rising clock edge. A read is combinational from the current register state and the live inputs.

The block receives the status of four request queues and four response queues from the queue engines. A request queue raises an interrupt while its status bit is 0, which means it has room. A response queue raises an interrupt while its status bit is 1, which means it holds work. Error events and a non-queued event are also interrupt sources. The mask word gates every source. The single interrupt output is level-sensitive and combinational.

A soft reset is issued by writing the command/status word with bit 0 set. It returns every stored field to its reset value at that same clock edge.

Top module: `qirq_regblk`

## Requirements
- R1: After reset, the configuration, error and mask words read 0. The command/status word shows only its live fields: queue status, idle and interrupt pending.
- R2: The configuration word (index 0) stores bits 5:0 as written and reads 0 in bits 31:6. Bits 2:0 hold the burst code (0 = 4, 4 = 16, 5 = 32, 6 = 64 words). Bit 3 selects enhanced bus mode, bit 4 enables parity checking and bit 5 enables parity test.
- R3: The error word (index 1) has three bits: bit 2 alignment, bit 1 unsupported access, bit 0 parity. A cycle with `sae_evt` high sets the bits given by `sae_kind`, and those bits stay set. Writing 1 to a bit clears it. If a set and a clear of the same bit fall in one cycle, the set wins.
- R4: Command/status bit 7 reads as the OR of the three error bits.
- R5: Command/status bits 19:16 show `rsp_stat[3:0]` and bits 11:8 show `req_stat[3:0]`, both live. Bit 1 shows `idle_in`. Every other bit not named in R6, R9 and R10 reads 0.
- R6: Command/status bit 2 is set by `nonq_evt` and stays set. Writing 1 to bit 2 clears it. An event in the same cycle as the clear wins.
- R7: The mask word (index 3) stores only bits 19:16, 11:8, 7 and 2. All other bits read 0.
- R8: `irq` is high in the same cycle whenever the OR of the following terms is non-zero. The terms are: `rsp_stat` gated by mask 19:16, inverted `req_stat` gated by mask 11:8, the error OR gated by mask 7, and the non-queued bit gated by mask 2.
- R9: Command/status bit 3 reads the current value of `irq`.
- R10: Writing command/status with bit 0 set clears configuration, error, non-queued and mask state at that edge. This overrides any error or non-queued event and any other write in the same cycle. Bit 0 always reads 0.
- R11: Writing command/status has no effect apart from bits 2 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_word | input | 2 | Register word index (0..3 = offsets 0x00..0x0C) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the indexed word |
| req_stat | input | 4 | Request queue status, 1 = full |
| rsp_stat | input | 4 | Response queue status, 1 = pending |
| sae_evt | input | 1 | Slave access error event |
| sae_kind | input | 3 | Error kinds for the event (R3 bit order) |
| nonq_evt | input | 1 | Non-queued event |
| idle_in | input | 1 | Controller idle status |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a sticky capture and the host's write-1-to-clear of the same bit; this applies to both the error word and the non-queued bit. The second pair is the soft reset and an incoming error event. The bench provokes each pair by asserting the event input during the clearing write. A behavioural model, updated once per clock, judges the outcome. It expects the set to survive a clear and the soft reset to override the set. Every read value and the interrupt level are compared against that model on each step.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NQ = 4;
  localparam int unsigned ERR_W = 3;
  localparam int unsigned CFG_W = 6;

  localparam logic [1:0] IDX_CFG = 2'd0;
  localparam logic [1:0] IDX_ERR = 2'd1;
  localparam logic [1:0] IDX_CSR = 2'd2;
  localparam logic [1:0] IDX_MSK = 2'd3;

  localparam int unsigned RSP_LSB  = 16;
  localparam int unsigned REQ_LSB  = 8;
  localparam int unsigned ERR_BIT  = 7;
  localparam int unsigned PEND_BIT = 3;
  localparam int unsigned NONQ_BIT = 2;
  localparam int unsigned IDLE_BIT = 1;
  localparam int unsigned SRST_BIT = 0;

  localparam logic [DW-1:0] MASK_WR = 32'h000F_0F84;

  function automatic logic [DW-1:0] irq_vector(
    input logic [NQ-1:0] rsp,
    input logic [NQ-1:0] req,
    input logic          err_any,
    input logic          nonq,
    input logic [DW-1:0] mask
  );
    logic [DW-1:0] v;
    v = '0;
    v[RSP_LSB +: NQ] = rsp;
    v[REQ_LSB +: NQ] = ~req;
    v[ERR_BIT]  = err_any;
    v[NONQ_BIT] = nonq;
    return v & mask;
  endfunction
endpackage

// File: rtl/qirq_cfg_reg.sv
module qirq_cfg_reg #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (soft_rst) q <= '0;
    else if (wr_en)    q <= wdata;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$past(soft_rst)) |-> $stable(q)); // R2
endmodule

// File: rtl/qirq_sticky.sv
module qirq_sticky #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (soft_rst) q <= '0;
    else               q <= (q & ~clr_bits) | set_bits;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(soft_rst) |-> ((($past(q) & ~$past(clr_bits)) & ~q) == '0)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(soft_rst) |-> ((q & $past(set_bits)) == $past(set_bits))); // R3
endmodule

// File: rtl/qirq_irq_calc.sv
module qirq_irq_calc
  import qirq_pkg::*;
(
  input  logic [NQ-1:0] rsp,
  input  logic [NQ-1:0] req,
  input  logic          err_any,
  input  logic          nonq,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] vec,
  output logic          irq
);
  always_comb begin
    vec = irq_vector(rsp, req, err_any, nonq, mask);
    irq = |vec;
  end

  always_comb begin
    if (irq) AST_IRQ_NEEDS_MASK: assert (mask != '0); // R8
  end
endmodule

// File: rtl/qirq_regblk.sv
module qirq_regblk
  import qirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [1:0]    host_word,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic [3:0]    req_stat,
  input  logic [3:0]    rsp_stat,
  input  logic          sae_evt,
  input  logic [2:0]    sae_kind,
  input  logic          nonq_evt,
  input  logic          idle_in,
  output logic          irq
);
  logic wr_cfg, wr_err, wr_csr, wr_msk, soft_rst;
  logic [CFG_W-1:0] cfg_q;
  logic [ERR_W-1:0] err_q, err_set, err_clr;
  logic [0:0]       nonq_q, nonq_set, nonq_clr;
  logic [DW-1:0]    mask_q, irq_vec, csr_val;
  logic             err_any;

  assign wr_cfg   = host_we && (host_word == IDX_CFG);
  assign wr_err   = host_we && (host_word == IDX_ERR);
  assign wr_csr   = host_we && (host_word == IDX_CSR);
  assign wr_msk   = host_we && (host_word == IDX_MSK);
  assign soft_rst = wr_csr && host_wdata[SRST_BIT];

  assign err_set  = sae_evt ? sae_kind : '0;
  assign err_clr  = wr_err ? host_wdata[ERR_W-1:0] : '0;
  assign nonq_set = nonq_evt;
  assign nonq_clr = wr_csr && host_wdata[NONQ_BIT];

  qirq_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(wr_cfg), .wdata(host_wdata[CFG_W-1:0]), .q(cfg_q)
  );

  qirq_sticky #(.W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .set_bits(err_set), .clr_bits(err_clr), .q(err_q)
  );

  qirq_sticky #(.W(1)) u_nonq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .set_bits(nonq_set), .clr_bits(nonq_clr), .q(nonq_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '0;
    else if (soft_rst) mask_q <= '0;
    else if (wr_msk)   mask_q <= host_wdata & MASK_WR;
  end

  assign err_any = |err_q;

  qirq_irq_calc u_irq (
    .rsp(rsp_stat), .req(req_stat), .err_any(err_any),
    .nonq(nonq_q[0]), .mask(mask_q), .vec(irq_vec), .irq(irq)
  );

  always_comb begin
    csr_val = '0;
    csr_val[RSP_LSB +: NQ] = rsp_stat;
    csr_val[REQ_LSB +: NQ] = req_stat;
    csr_val[ERR_BIT]  = err_any;
    csr_val[PEND_BIT] = irq;
    csr_val[NONQ_BIT] = nonq_q[0];
    csr_val[IDLE_BIT] = idle_in;
  end

  always_comb begin
    unique case (host_word)
      IDX_CFG: host_rdata = {{(DW-CFG_W){1'b0}}, cfg_q};
      IDX_ERR: host_rdata = {{(DW-ERR_W){1'b0}}, err_q};
      IDX_CSR: host_rdata = csr_val;
      default: host_rdata = mask_q;
    endcase
  end

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (cfg_q == '0 && err_q == '0 && nonq_q == '0 && mask_q == '0)); // R10
  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R8
  AST_CSR_NOT_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    (host_word == IDX_CSR) |-> !host_rdata[SRST_BIT]); // R10
  AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_word == IDX_CSR) |-> (host_rdata[PEND_BIT] == (irq_vec != '0))); // R9
endmodule

// File: tb/qirq_regblk_tb.sv
`timescale 1ns/1ps
module qirq_regblk_tb;
  logic clk = 0, rst_n = 0;
  logic host_we = 0;
  logic [1:0] host_word = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic [3:0] req_stat = 4'hF, rsp_stat = 0;
  logic sae_evt = 0, nonq_evt = 0, idle_in = 0, irq;
  logic [2:0] sae_kind = 0;

  int n_run = 0, n_fail = 0;
  logic [5:0]  m_cfg = 0;
  logic [2:0]  m_err = 0;
  logic        m_nonq = 0;
  logic [31:0] m_mask = 0;

  always #2.5 clk = ~clk;

  qirq_regblk u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_word(host_word),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .req_stat(req_stat),
    .rsp_stat(rsp_stat), .sae_evt(sae_evt), .sae_kind(sae_kind),
    .nonq_evt(nonq_evt), .idle_in(idle_in), .irq(irq)
  );

  function automatic logic exp_irq();
    logic r = 0;
    for (int i = 0; i < 4; i++) begin
      if (rsp_stat[i] && m_mask[16+i]) r = 1;
      if (!req_stat[i] && m_mask[8+i]) r = 1;
    end
    if ((m_err != 0) && m_mask[7]) r = 1;
    if (m_nonq && m_mask[2]) r = 1;
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] w);
    logic [31:0] v = 0;
    case (w)
      2'd0: v = 32'(m_cfg);
      2'd1: v = 32'(m_err);
      2'd2: begin
        v = v + (32'(rsp_stat) << 16) + (32'(req_stat) << 8);
        if (m_err != 0) v = v + 32'h80;
        if (exp_irq())  v = v + 32'h8;
        if (m_nonq)     v = v + 32'h4;
        if (idle_in)    v = v + 32'h2;
      end
      default: v = m_mask;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [1:0] w,
                      input logic [31:0] wd, input logic [3:0] rq, input logic [3:0] rs,
                      input logic se, input logic [2:0] sk, input logic ne, input logic idl);
    @(negedge clk);
    host_we = we; host_word = w; host_wdata = wd; req_stat = rq; rsp_stat = rs;
    sae_evt = se; sae_kind = sk; nonq_evt = ne; idle_in = idl;
    #1;
    check({tag, " rdata"}, host_rdata, exp_read(w));
    check("R8 irq", {31'b0, irq}, {31'b0, exp_irq()});
    @(posedge clk);
    if (we && w == 2'd2 && wd[0]) begin
      m_cfg = 0; m_err = 0; m_nonq = 0; m_mask = 0;
    end else begin
      if (we && w == 2'd0) m_cfg = wd[5:0];
      m_err = (m_err & ~((we && w == 2'd1) ? wd[2:0] : 3'b0)) | (se ? sk : 3'b0);
      m_nonq = (m_nonq && !(we && w == 2'd2 && wd[2])) || ne;
      if (we && w == 2'd3) m_mask = wd & 32'h000F_0F84;
    end
  endtask

  task automatic rd(input string tag, input logic [1:0] w);
    step(tag, 0, w, 0, req_stat, rsp_stat, 0, 0, 0, idle_in);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    rd("R1", 0); rd("R1", 1); rd("R1", 2); rd("R1", 3);
    // R2 configuration
    step("R2", 1, 0, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, 0, 0);
    rd("R2", 0);
    step("R2", 1, 0, 32'h0000_0016, 4'hF, 0, 0, 0, 0, 0);
    rd("R2", 0);
    // R3 / R4 error capture
    step("R3", 0, 1, 0, 4'hF, 0, 1, 3'b101, 0, 0);
    rd("R3", 1); rd("R4", 2);
    step("R3", 1, 1, 32'h1, 4'hF, 0, 0, 0, 0, 0);
    rd("R3", 1);
    step("R3", 1, 1, 32'h4, 4'hF, 0, 1, 3'b100, 0, 0);
    rd("R3", 1);
    step("R3", 1, 1, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, 0, 0);
    rd("R3", 1); rd("R4", 2);
    // R5 live status
    step("R5", 0, 2, 0, 4'b1010, 4'b0110, 0, 0, 0, 1);
    step("R5", 0, 2, 0, 4'b0101, 4'b1001, 0, 0, 0, 0);
    // R7 mask
    step("R7", 1, 3, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, 0, 0);
    rd("R7", 3);
    // R8 / R9 sources
    step("R8", 0, 2, 0, 4'hF, 0, 0, 0, 0, 0);
    step("R9", 0, 2, 0, 4'hF, 4'b0100, 0, 0, 0, 0);
    step("R9", 0, 2, 0, 4'b1110, 0, 0, 0, 0, 0);
    step("R8", 1, 3, 32'h0000_0080, 4'h0, 4'hF, 0, 0, 0, 0);
    step("R8", 0, 2, 0, 4'h0, 4'hF, 1, 3'b010, 0, 0);
    step("R8", 1, 1, 32'h2, 4'h0, 4'hF, 0, 0, 0, 0);
    rd("R8", 2);
    // R6 non-queued
    step("R6", 1, 3, 32'h0000_0004, 4'hF, 0, 0, 0, 1, 0);
    rd("R6", 2);
    step("R6", 1, 2, 32'h4, 4'hF, 0, 0, 0, 1, 0);
    rd("R6", 2);
    step("R6", 1, 2, 32'h4, 4'hF, 0, 0, 0, 0, 0);
    rd("R6", 2);
    // R11 other CSR bits read-only
    step("R11", 1, 0, 32'h25, 4'hF, 0, 1, 3'b001, 1, 0);
    step("R11", 1, 2, 32'hFFFF_FFFA, 4'hF, 0, 0, 0, 0, 0);
    rd("R11", 0); rd("R11", 1); rd("R11", 2); rd("R11", 3);
    // R10 soft reset overriding events
    step("R10", 1, 3, 32'h000F_0F84, 4'hF, 0, 0, 0, 0, 0);
    step("R10", 1, 2, 32'h1, 4'h3, 4'h1, 1, 3'b111, 1, 1);
    rd("R10", 0); rd("R10", 1); rd("R10", 2); rd("R10", 3);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule